// File: doc/BRIEF.md
# Three-wire serial EEPROM master

This block runs a word-organised serial EEPROM on behalf of a host. The EEPROM sits on a chip select, a serial clock, a data line toward the memory and a data line back from it. The host presents a command (read word, write word, allow writes, forbid writes), an 8-bit word address and a 16-bit data word, then pulses `start` for one cycle. The block turns the command into a bit stream and clocks it out with every phase stretched by a parameterised delay. For a read it clocks the word back in. For a write it frames the programming command between an enable and a disable and waits for the memory to signal that it is ready.

Every command ends with chip select held low for one delay period, after which `done` pulses for one cycle. If the memory does not report ready within a parameterised number of delay periods, a timeout flag is raised and stays set until the next accepted command.

Top module: `sereep_master`

## Requirements
- R1: A read (cmd 0) sends 11 bits MSB first: start bit 1, wire opcode 10, then the 8 address bits. It then issues 16 more clock pulses in the same chip-select window, 27 pulses in total.
- R2: Each output bit uses three phases of DLY cycles each, with chip select high: data set with clock low, then clock high, then clock low. The data line never changes while the clock is high, and the clock is never high while chip select is low.
- R3: Read data is sampled at the end of each clock-high phase and shifted in at the LSB, so the first bit received is bit 15. `rdata` changes only in the cycle `done` pulses at the end of a read, and keeps its value through any other command.
- R4: Chip select stays low for exactly DLY cycles between frames inside one command, and also after the last frame before `done` pulses.
- R5: Write enable (cmd 2) sends one frame of 11 bits: 1, 0, 0 and then eight 1s.
- R6: Write disable (cmd 3) sends one frame of 11 bits: a 1 followed by ten 0s.
- R7: A word write (cmd 1) sends four chip-select windows in this order. First the enable frame of R5. Then a 27-bit frame made of start bit 1, wire opcode 01, the 8 address bits and the 16 data bits, all MSB first. Then a ready-poll window. Then the disable frame of R6.
- R8: In the ready-poll window, chip select is high with the clock and data line low. The data-in line is sampled once per DLY cycles, and the window closes on the first sample that reads 1.
- R9: If POLL_MAX samples in a row read 0, `timeout` is set and the poll window closes. The disable frame is still sent. `timeout` is high when `done` pulses, stays high, and clears in the cycle after the next accepted `start`.
- R10: A `start` seen while `busy` is high is ignored. No extra frames appear, and the memory contents are left unchanged.
- R11: `busy` is high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R12: After reset, chip select, clock, data out, `busy`, `done` and `timeout` are low, and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command request |
| cmd | input | 2 | 0 read, 1 write, 2 allow writes, 3 forbid writes |
| addr | input | 8 | Word address |
| wdata | input | 16 | Word to program |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Ready poll gave up on the last write |
| rdata | output | 16 | Last word read |
| mem_cs | output | 1 | Memory chip select |
| mem_sk | output | 1 | Memory serial clock |
| mem_mosi | output | 1 | Serial data toward the memory |
| mem_miso | input | 1 | Serial data and ready status from the memory |

## Verification
The assertions assume that `mem_miso` is synchronous to `clk`, and that `cmd`, `addr` and `wdata` only need to be valid in the cycle an accepted `start` is high. They do not assume that `start` stays low while the block is busy. The memory stub in the bench updates its data-out line one clock after it sees a rising serial clock, so the bench runs with DLY of three. That keeps every response settled well before the block samples it. The stub's ready delay is either short, which gives a normal poll, or far longer than POLL_MAX delay periods, which forces the timeout path. One directed case also pulses `start` in the middle of a read.

// File: rtl/sereep_master.sv
module sereep_master #(
  parameter int DLY      = 4,
  parameter int POLL_MAX = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  cmd,
  input  logic [7:0]  addr,
  input  logic [15:0] wdata,
  output logic        busy,
  output logic        done,
  output logic        timeout,
  output logic [15:0] rdata,
  output logic        mem_cs,
  output logic        mem_sk,
  output logic        mem_mosi,
  input  logic        mem_miso
);

  localparam int TW  = (DLY > 1) ? $clog2(DLY) : 1;
  localparam int PCW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

  localparam logic [1:0] CMD_RD   = 2'd0;
  localparam logic [1:0] CMD_WR   = 2'd1;
  localparam logic [1:0] CMD_WEN  = 2'd2;
  localparam logic [1:0] CMD_WDIS = 2'd3;

  localparam logic [1:0] WIRE_RD  = 2'b10;
  localparam logic [1:0] WIRE_WR  = 2'b01;
  localparam logic [1:0] WIRE_CTL = 2'b00;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_READ, S_GAP, S_POLL} st_t;

  st_t              st;
  logic [1:0]       cmd_q;
  logic [7:0]       addr_q;
  logic [15:0]      wdata_q;
  logic [26:0]      shreg;
  logic [4:0]       nbits;
  logic [1:0]       ph;
  logic [1:0]       stage;
  logic [TW-1:0]    tmr;
  logic [PCW-1:0]   pcnt;
  logic [15:0]      rx;
  logic [15:0]      rdata_q;
  logic             done_q;
  logic             tout_q;
  logic             tick;

  function automatic logic [26:0] mkframe(input logic [1:0] c, input logic [7:0] a,
                                          input logic [15:0] d);
    return {1'b1, c, a, d};
  endfunction

  assign tick = (tmr == TW'(DLY - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd_q   <= CMD_RD;
      addr_q  <= '0;
      wdata_q <= '0;
      shreg   <= '0;
      nbits   <= '0;
      ph      <= '0;
      stage   <= '0;
      tmr     <= '0;
      pcnt    <= '0;
      rx      <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st != S_IDLE) tmr <= tick ? '0 : tmr + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          cmd_q   <= cmd;
          addr_q  <= addr;
          wdata_q <= wdata;
          tout_q  <= 1'b0;
          stage   <= '0;
          ph      <= '0;
          tmr     <= '0;
          nbits   <= 5'd10;
          st      <= S_SEND;
          case (cmd)
            CMD_RD:   shreg <= mkframe(WIRE_RD, addr, 16'h0);
            CMD_WDIS: shreg <= mkframe(WIRE_CTL, 8'h00, 16'h0);
            default:  shreg <= mkframe(WIRE_CTL, 8'hFF, 16'h0);
          endcase
        end
        S_SEND: if (tick) begin
          if (ph != 2'd2) ph <= ph + 1'b1;
          else begin
            ph <= '0;
            if (nbits == '0) begin
              if (cmd_q == CMD_RD) begin
                st    <= S_READ;
                nbits <= 5'd15;
              end else st <= S_GAP;
            end else begin
              shreg <= shreg << 1;
              nbits <= nbits - 1'b1;
            end
          end
        end
        S_READ: if (tick) begin
          if (ph == '0) begin
            rx <= {rx[14:0], mem_miso};
            ph <= 2'd1;
          end else begin
            ph <= '0;
            if (nbits == '0) st <= S_GAP;
            else nbits <= nbits - 1'b1;
          end
        end
        S_POLL: if (tick) begin
          if (mem_miso) st <= S_GAP;
          else if (pcnt == PCW'(POLL_MAX - 1)) begin
            tout_q <= 1'b1;
            st     <= S_GAP;
          end else pcnt <= pcnt + 1'b1;
        end
        S_GAP: if (tick) begin
          if (cmd_q != CMD_WR || stage == 2'd3) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            if (cmd_q == CMD_RD) rdata_q <= rx;
          end else begin
            stage <= stage + 1'b1;
            case (stage)
              2'd0: begin
                shreg <= mkframe(WIRE_WR, addr_q, wdata_q);
                nbits <= 5'd26;
                st    <= S_SEND;
              end
              2'd1: begin
                pcnt <= '0;
                st   <= S_POLL;
              end
              default: begin
                shreg <= mkframe(WIRE_CTL, 8'h00, 16'h0);
                nbits <= 5'd10;
                st    <= S_SEND;
              end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign timeout  = tout_q;
  assign rdata    = rdata_q;
  assign mem_cs   = (st == S_SEND) || (st == S_READ) || (st == S_POLL);
  assign mem_sk   = ((st == S_SEND) && (ph == 2'd1)) || ((st == S_READ) && (ph == 2'd0));
  assign mem_mosi = ((st == S_SEND) || (st == S_READ)) && shreg[26];

  assert_sk_inside_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs |-> !mem_sk);

  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sk |-> $stable(mem_mosi));

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);

  assert_gap_before_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!mem_cs));

  assert_timeout_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (busy && !mem_cs && cmd_q == CMD_WR));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(cmd_q) && $stable(addr_q) && $stable(wdata_q)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_cs && !mem_sk));

endmodule

// File: tb/sereep_master_tb_top.sv
module sereep_master_tb_top;
  localparam int DLY      = 3;
  localparam int POLL_MAX = 8;
  localparam int LIMIT    = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd = '0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        busy, done, timeout, mem_cs, mem_sk, mem_mosi, mem_miso;
  logic [15:0] rdata;

  int checks = 0;
  int fails  = 0;
  int stub_busy_len = 10;

  always #10 clk = ~clk;

  sereep_master #(.DLY(DLY), .POLL_MAX(POLL_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .timeout(timeout), .rdata(rdata),
    .mem_cs(mem_cs), .mem_sk(mem_sk), .mem_mosi(mem_mosi), .mem_miso(mem_miso));

  // memory stub
  logic [15:0] smem [256];
  logic        sk_d, rd_mode, miso_r, we;
  logic [26:0] sr;
  logic [1:0]  s_op;
  logic [7:0]  s_a;
  logic [3:0]  ridx;
  int          n, busy_cnt;

  always @(posedge clk) begin
    logic [10:0] hdr;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) smem[i] <= {8'(i), ~8'(i)};
      sk_d <= 1'b0; rd_mode <= 1'b0; miso_r <= 1'b0; we <= 1'b0;
      n <= 0; busy_cnt <= 0; sr <= '0; s_op <= '0; s_a <= '0; ridx <= '0;
    end else begin
      sk_d <= mem_sk;
      if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (!mem_cs) begin
        n <= 0;
        rd_mode <= 1'b0;
      end else if (mem_sk && !sk_d) begin
        if (rd_mode) begin
          miso_r <= smem[s_a][4'd15 - ridx];
          ridx   <= ridx + 1'b1;
        end else begin
          n  <= n + 1;
          sr <= {sr[25:0], mem_mosi};
          if (n == 10) begin
            hdr = {sr[9:0], mem_mosi};
            s_op <= hdr[9:8];
            s_a  <= hdr[7:0];
            if (hdr[9:8] == 2'b10) begin
              rd_mode <= 1'b1;
              ridx    <= '0;
            end
            if (hdr[9:8] == 2'b00 && hdr[7:6] == 2'b11) we <= 1'b1;
            if (hdr[9:8] == 2'b00 && hdr[7:6] == 2'b00) we <= 1'b0;
          end
          if (n == 26 && s_op == 2'b01 && we) begin
            smem[s_a] <= {sr[14:0], mem_mosi};
            busy_cnt  <= stub_busy_len;
          end
        end
      end
    end
  end

  assign mem_miso = rd_mode ? miso_r : (busy_cnt == 0);

  // frame monitor
  logic        cs_p = 1'b0, sk_p = 1'b0, busy_p = 1'b0;
  int          lowcnt = 0, skcnt = 0, nfr = 0, done_gap = 0;
  logic [31:0] cur = '0;
  logic [31:0] fbits [8];
  int          fsk [8];
  int          fgap [8];

  always @(negedge clk) begin
    if (busy && !busy_p) nfr = 0;
    if (mem_cs && !cs_p) begin
      if (nfr > 0 && nfr <= 8) fgap[nfr-1] = lowcnt;
      skcnt = 0;
      cur = '0;
    end
    if (mem_cs && mem_sk && !sk_p) begin
      skcnt++;
      cur = {cur[30:0], mem_mosi};
    end
    if (!mem_cs && cs_p) begin
      if (nfr < 8) begin
        fsk[nfr] = skcnt;
        fbits[nfr] = cur;
      end
      nfr++;
    end
    if (done) done_gap = lowcnt;
    lowcnt = mem_cs ? 0 : lowcnt + 1;
    cs_p = mem_cs;
    sk_p = mem_sk;
    busy_p = busy;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] c, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd = c; addr = a; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 busy after start", 32'(busy), 32'd1);
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < LIMIT) begin
      @(negedge clk);
      k++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R11 watchdog actual=no_done expected=done");
    end else chk("R11 busy low with done", 32'(busy), 32'd0);
    @(posedge clk);
    #1;
    chk("R11 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic run_op(input logic [1:0] c, input logic [7:0] a, input logic [15:0] d,
                        input logic [15:0] exp);
    launch(c, a, d);
    wait_done();
    chk("R4 final gap", done_gap, DLY);
    chk("R3 rdata", 32'(rdata), 32'(exp));
    case (c)
      2'd0: begin
        chk("R1 frame count", nfr, 1);
        chk("R1 clocks", fsk[0], 27);
        chk("R1 header", 32'(fbits[0][26:16]), 32'({1'b1, 2'b10, a}));
      end
      2'd1: begin
        chk("R7 frame count", nfr, 4);
        chk("R7 enable clocks", fsk[0], 11);
        chk("R7 enable bits", 32'(fbits[0][10:0]), 32'h4FF);
        chk("R7 frame clocks", fsk[1], 27);
        chk("R7 frame bits", 32'(fbits[1][26:0]), 32'({1'b1, 2'b01, a, d}));
        chk("R8 poll has no clock", fsk[2], 0);
        chk("R7 disable clocks", fsk[3], 11);
        chk("R7 disable bits", 32'(fbits[3][10:0]), 32'h400);
        for (int g = 0; g < 3; g++) chk("R4 inner gap", fgap[g], DLY);
        chk("R7 device protected", 32'(we), 32'd0);
      end
      2'd2: begin
        chk("R5 frame count", nfr, 1);
        chk("R5 clocks", fsk[0], 11);
        chk("R5 bits", 32'(fbits[0][10:0]), 32'h4FF);
        chk("R5 device enabled", 32'(we), 32'd1);
      end
      default: begin
        chk("R6 frame count", nfr, 1);
        chk("R6 clocks", fsk[0], 11);
        chk("R6 bits", 32'(fbits[0][10:0]), 32'h400);
        chk("R6 device disabled", 32'(we), 32'd0);
      end
    endcase
  endtask

  // {cmd, addr, wdata, expected rdata after the command}
  localparam logic [41:0] VEC [9] = '{
    {2'd0, 8'h00, 16'h0000, 16'h00FF},
    {2'd0, 8'hFF, 16'h0000, 16'hFF00},
    {2'd1, 8'h12, 16'hA5C3, 16'hFF00},
    {2'd0, 8'h12, 16'h0000, 16'hA5C3},
    {2'd1, 8'h80, 16'h0001, 16'hA5C3},
    {2'd0, 8'h80, 16'h0000, 16'h0001},
    {2'd2, 8'h00, 16'h0000, 16'h0001},
    {2'd3, 8'h00, 16'h0000, 16'h0001},
    {2'd0, 8'h5A, 16'h0000, 16'h5AA5}
  };

  initial begin
    repeat (4) @(negedge clk);
    chk("R12 cs", 32'(mem_cs), 32'd0);
    chk("R12 sk", 32'(mem_sk), 32'd0);
    chk("R12 mosi", 32'(mem_mosi), 32'd0);
    chk("R12 busy", 32'(busy), 32'd0);
    chk("R12 done", 32'(done), 32'd0);
    chk("R12 timeout", 32'(timeout), 32'd0);
    chk("R12 rdata", 32'(rdata), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 9; v++)
      run_op(VEC[v][41:40], VEC[v][39:32], VEC[v][31:16], VEC[v][15:0]);

    // R10: start during a read is dropped
    launch(2'd0, 8'h12, 16'h0);
    repeat (5) @(negedge clk);
    cmd = 2'd1; addr = 8'h12; wdata = 16'hDEAD; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R10 single frame", nfr, 1);
    chk("R10 read value", 32'(rdata), 32'hA5C3);
    run_op(2'd0, 8'h12, 16'h0, 16'hA5C3);

    // R9: device never ready inside the poll window
    stub_busy_len = 600;
    run_op(2'd1, 8'h33, 16'hBEEF, 16'hA5C3);
    chk("R9 timeout at done", 32'(timeout), 32'd1);
    repeat (10) @(negedge clk);
    chk("R9 timeout held", 32'(timeout), 32'd1);
    repeat (700) @(negedge clk);
    stub_busy_len = 10;
    launch(2'd0, 8'h33, 16'h0);
    chk("R9 timeout cleared", 32'(timeout), 32'd0);
    wait_done();
    chk("R8 stored word", 32'(rdata), 32'hBEEF);

    // R8: normal write after timeout completes without flag
    run_op(2'd1, 8'h44, 16'h1234, 16'hBEEF);
    chk("R8 no timeout", 32'(timeout), 32'd0);
    run_op(2'd0, 8'h44, 16'h0, 16'h1234);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule